// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the device end of a serial configuration chain. An external host supplies a configuration clock and one data bit per rising edge. After the program input is released, the receiver runs a short memory-clear phase with init held low. It then takes a fixed-size frame made of a payload followed by a 16-bit check value. The payload is packed into words and written to a local store through a parallel write port.

When the last bit of its own frame arrives, the receiver compares the check value with a CRC it has computed over the payload. On a match it raises done and from then on relays every later bit to its data output, which changes on the falling clock edge, so the next device in the chain can load in turn. On a mismatch it pulls init low, keeps done low and relays nothing. Holding program low aborts everything, and the whole sequence starts again when program returns high.

Top module: `serial_cfg_rx`

## Requirements
- R1: Data is sampled on the rising edge of cfg_clk. Each group of WORD_W payload bits forms one word, with the first bit received as the MSB. One cycle after the rising edge that samples the word's last bit, store_we is high for exactly one cycle, with store_data holding the word and store_addr holding its index, counting from 0.
- R2: After prog_n goes high, init_n stays low for CLEAR_CYCLES rising edges and then goes high. The bit sampled on the edge after that is frame bit 0.
- R3: Bits sampled during the clear phase are ignored: they cause no store write and do not count toward the frame.
- R4: The CRC uses polynomial 0x1021 and a start value of 0xFFFF. Bits are processed MSB first, one per payload bit. The result is compared with the last 16 frame bits, with the first of those bits as the MSB. On a mismatch, init_n goes low one cycle after the final frame bit and stays low, and done stays low, until the next prog_n pulse.
- R5: On a match, done goes high one cycle after the final frame bit and stays high until prog_n goes low. Done is low at all other times.
- R6: Once done is high, each bit sampled on a rising edge appears on dout from the next falling edge until the falling edge after that.
- R7: dout is low before forwarding begins and after a CRC failure.
- R8: While forwarding, incoming bits cause no store write.
- R9: While prog_n is low, init_n, done, dout and store_we are low at once. The receiver restarts from the clear phase, with word index 0 and a fresh CRC, when prog_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock from the host |
| prog_n | input | 1 | Active-low program; low resets the receiver asynchronously |
| din | input | 1 | Serial configuration data |
| dout | output | 1 | Relayed data for the next device, changes on falling edge |
| init_n | output | 1 | Active-low init: low in clear phase, on CRC failure and in program |
| done | output | 1 | High once the own frame has loaded with a good CRC |
| store_we | output | 1 | One-cycle write strobe for the local store |
| store_addr | output | ADDR_W | Word index of the write |
| store_data | output | WORD_W | Assembled payload word |

## Verification
A bit counter that is off by even one position shifts every word boundary. This shows up within WORD_W cycles as a misplaced store_we or a wrong store_data value, and at frame end as a false CRC verdict on init_n and done. A CRC register that was not reset, or that takes a clear-phase bit, flips the verdict at the frame's final edge. A state that enters or leaves forwarding at the wrong edge shows on dout within one cycle. The reference model is compared against every output on every clock, so each of these is caught in the cycle it first appears.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RELAY = 2'd2,
        ST_FAIL  = 2'd3
    } rx_state_e;

    localparam int CHK_BITS = 16;
    localparam logic [CHK_BITS-1:0] CRC_POLY = 16'h1021;
    localparam logic [CHK_BITS-1:0] CRC_SEED = 16'hFFFF;

    function automatic logic [CHK_BITS-1:0] crc_advance(
        input logic [CHK_BITS-1:0] cur,
        input logic                bit_in
    );
        logic feedback;
        feedback = cur[CHK_BITS-1] ^ bit_in;
        return {cur[CHK_BITS-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/cfg_rx_crc.sv
module cfg_rx_crc
    import cfg_rx_pkg::*;
(
    input  logic                cfg_clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                bit_in,
    output logic [CHK_BITS-1:0] crc
);

    logic [CHK_BITS-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (en) begin
            crc_d = crc_advance(crc_q, bit_in);
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/cfg_rx_deser.sv
module cfg_rx_deser #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data
);

    localparam int FILL_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [FILL_W-1:0] fill;
        logic [ADDR_W-1:0] idx;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } deser_t;

    deser_t r_d, r_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        shifted = {r_q.shreg[WORD_W-2:0], bit_in};
        if (shift_en) begin
            r_d.shreg = shifted;
            if (r_q.fill == FILL_LAST) begin
                r_d.fill = '0;
                r_d.we   = 1'b1;
                r_d.data = shifted;
                r_d.addr = r_q.idx;
                r_d.idx  = r_q.idx + 1'b1;
            end else begin
                r_d.fill = r_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign we   = r_q.we;
    assign addr = r_q.addr;
    assign data = r_q.data;

endmodule

// File: rtl/cfg_rx_fwd.sv
module cfg_rx_fwd (
    input  logic cfg_clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic dout
);

    logic dout_d, dout_q;

    always_comb begin
        dout_d = bit_in;
    end

    always_ff @(negedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
    import cfg_rx_pkg::*;
#(
    parameter int PAYLOAD_BITS = 32,
    parameter int WORD_W       = 8,
    parameter int CLEAR_CYCLES = 6,
    localparam int WORDS       = PAYLOAD_BITS / WORD_W,
    localparam int ADDR_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              cfg_clk,
    input  logic              prog_n,
    input  logic              din,
    output logic              dout,
    output logic              init_n,
    output logic              done,
    output logic              store_we,
    output logic [ADDR_W-1:0] store_addr,
    output logic [WORD_W-1:0] store_data
);

    localparam int FRAME_BITS = PAYLOAD_BITS + CHK_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int CLR_W      = $clog2(CLEAR_CYCLES + 1);
    localparam logic [CNT_W-1:0] PAY_END   = CNT_W'(PAYLOAD_BITS);
    localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS - 1);
    localparam logic [CLR_W-1:0] CLR_END   = CLR_W'(CLEAR_CYCLES - 1);

    typedef struct packed {
        rx_state_e           state;
        logic [CLR_W-1:0]    clr_cnt;
        logic [CNT_W-1:0]    bit_cnt;
        logic [CHK_BITS-1:0] chk;
        logic                fwd;
    } rx_t;

    rx_t r_d, r_q;

    logic                in_payload;
    logic [CHK_BITS-1:0] crc_val;
    logic [CHK_BITS-1:0] chk_next;

    assign in_payload = (r_q.state == ST_LOAD) && (r_q.bit_cnt < PAY_END);
    assign chk_next   = {r_q.chk[CHK_BITS-2:0], din};

    always_comb begin
        r_d     = r_q;
        r_d.fwd = (r_q.state == ST_RELAY) ? din : 1'b0;
        case (r_q.state)
            ST_CLEAR: begin
                if (r_q.clr_cnt == CLR_END) begin
                    r_d.state = ST_LOAD;
                end else begin
                    r_d.clr_cnt = r_q.clr_cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                if (!in_payload) begin
                    r_d.chk = chk_next;
                end
                if (r_q.bit_cnt == FRAME_END) begin
                    r_d.state = (chk_next == crc_val) ? ST_RELAY : ST_FAIL;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge cfg_clk or negedge prog_n) begin
        if (!prog_n) begin
            r_q <= '{state: ST_CLEAR, clr_cnt: '0, bit_cnt: '0, chk: '0, fwd: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    cfg_rx_crc u_crc (
        .cfg_clk (cfg_clk),
        .rst_n   (prog_n),
        .en      (in_payload),
        .bit_in  (din),
        .crc     (crc_val)
    );

    cfg_rx_deser #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_deser (
        .cfg_clk  (cfg_clk),
        .rst_n    (prog_n),
        .shift_en (in_payload),
        .bit_in   (din),
        .we       (store_we),
        .addr     (store_addr),
        .data     (store_data)
    );

    cfg_rx_fwd u_fwd (
        .cfg_clk (cfg_clk),
        .rst_n   (prog_n),
        .bit_in  (r_q.fwd),
        .dout    (dout)
    );

    assign init_n = prog_n && ((r_q.state == ST_LOAD) || (r_q.state == ST_RELAY));
    assign done   = (r_q.state == ST_RELAY);

endmodule

// File: rtl/cfg_rx_chk.sv
module cfg_rx_chk (
    input logic cfg_clk,
    input logic prog_n,
    input logic init_n,
    input logic done,
    input logic dout,
    input logic store_we
);

    // R5: once done, stays done while program is high
    a_r5_done_sticky: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |=> done);

    // R5 / R4: done and a pulled-down init never coexist
    a_r4_done_implies_init: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |-> init_n);

    // R8: no store writes while relaying
    a_r8_no_write_relay: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |-> !store_we);

    // R7: data output quiet until relaying has begun
    a_r7_dout_quiet: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        !done |-> !dout);

    // R1: write strobe lasts a single cycle
    a_r1_we_single: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        store_we |=> !store_we);

    // R2: no write while init is held low
    a_r2_no_write_in_init: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        !init_n |-> !store_we);

endmodule

bind serial_cfg_rx cfg_rx_chk u_chk (
    .cfg_clk  (cfg_clk),
    .prog_n   (prog_n),
    .init_n   (init_n),
    .done     (done),
    .dout     (dout),
    .store_we (store_we)
);

// File: tb/tb_serial_cfg_rx.sv
`timescale 1ns/1ps
module tb_serial_cfg_rx;

    localparam int PAY   = 32;
    localparam int WW    = 8;
    localparam int CLR   = 6;
    localparam int FRAME = PAY + 16;
    localparam int AW    = 2;

    logic          cfg_clk = 1'b0;
    logic          prog_n  = 1'b0;
    logic          din     = 1'b0;
    logic          dout, init_n, done, store_we;
    logic [AW-1:0] store_addr;
    logic [WW-1:0] store_data;

    int checks = 0;
    int fails  = 0;

    serial_cfg_rx #(.PAYLOAD_BITS(PAY), .WORD_W(WW), .CLEAR_CYCLES(CLR)) dut (
        .cfg_clk(cfg_clk), .prog_n(prog_n), .din(din), .dout(dout),
        .init_n(init_n), .done(done), .store_we(store_we),
        .store_addr(store_addr), .store_data(store_data)
    );

    always #5 cfg_clk = ~cfg_clk;

    // reference model: 0 clear, 1 load, 2 relay, 3 fail
    int m_state, m_clr, m_cnt, m_word, m_rxchk, m_addr;
    bit m_we, m_fwd;
    int m_data;
    bit pay_q[$];

    function automatic int ref_crc();
        int c = 16'hFFFF;
        foreach (pay_q[i]) begin
            bit top = ((c >> 15) & 1) != 0;
            c = (c << 1) & 16'hFFFF;
            if (top != pay_q[i]) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    always @(posedge cfg_clk or negedge prog_n) begin
        if (!prog_n) begin
            m_state = 0; m_clr = 0; m_cnt = 0; m_word = 0; m_rxchk = 0;
            m_we = 0; m_fwd = 0; m_addr = 0; m_data = 0;
            pay_q.delete();
        end else begin
            m_fwd = (m_state == 2) ? din : 1'b0;
            m_we  = 0;
            if (m_state == 0) begin
                if (m_clr == CLR - 1) m_state = 1; else m_clr++;
            end else if (m_state == 1) begin
                if (m_cnt < PAY) begin
                    pay_q.push_back(din);
                    m_word = ((m_word << 1) | din) & ((1 << WW) - 1);
                    if (m_cnt % WW == WW - 1) begin
                        m_we = 1; m_data = m_word; m_addr = m_cnt / WW;
                    end
                end else begin
                    m_rxchk = ((m_rxchk << 1) | din) & 16'hFFFF;
                end
                if (m_cnt == FRAME - 1) m_state = (m_rxchk == ref_crc()) ? 2 : 3;
                m_cnt++;
            end
        end
    end

    task automatic chk1(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        string t_init, t_st, t_do;
        bit exp_init;
        exp_init = prog_n && (m_state == 1 || m_state == 2);
        t_init = !prog_n ? "R9" : (m_state == 3) ? "R4" : "R2";
        t_st   = !prog_n ? "R9" : (m_state == 0) ? "R3" : (m_state == 2) ? "R8" : "R1";
        t_do   = (m_state == 2) ? "R6" : "R7";
        chk1(t_init, "init_n", init_n, exp_init);
        chk1("R5", "done", done, (m_state == 2));
        chk1(t_st, "store_we", store_we, m_we);
        if (m_we) begin
            chk1("R1", "store_data", store_data, m_data);
            chk1("R1", "store_addr", store_addr, m_addr);
        end
        chk1(t_do, "dout", dout, m_fwd);
    endtask

    task automatic step(bit b);
        @(negedge cfg_clk);
        din = b;
        #4 compare();
    endtask

    task automatic hold_prog(int n);
        @(negedge cfg_clk);
        prog_n = 0; din = 1;
        #4 compare();
        for (int i = 1; i < n; i++) step(1);
    endtask

    task automatic release_and_clear();
        @(negedge cfg_clk);
        prog_n = 1; din = 1;
        #4 compare();
        for (int i = 1; i < CLR; i++) step(i[0]);   // R3: junk during clear
    endtask

    function automatic logic [15:0] crc_of(logic [PAY-1:0] p);
        logic [15:0] c = 16'hFFFF;
        for (int i = PAY - 1; i >= 0; i--) begin
            logic f = c[15] ^ p[i];
            c = {c[14:0], 1'b0};
            if (f) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic send_frame(logic [PAY-1:0] p, bit corrupt, int upto);
        logic [15:0] c;
        c = crc_of(p) ^ {15'd0, corrupt};
        for (int i = PAY - 1; i >= 0; i--) begin
            if (PAY - 1 - i >= upto) return;
            step(p[i]);
        end
        for (int i = 15; i >= 0; i--) step(c[i]);
    endtask

    task automatic relay(logic [31:0] pat, int n);
        for (int i = 0; i < n; i++) step(pat[i % 32]);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        hold_prog(3);
        // good frame, then relay (R1 R2 R3 R5 R6 R8)
        release_and_clear();
        send_frame(32'hA5C3_0F81, 1'b0, FRAME);
        relay(32'hDEAD_BEEF, 24);
        // R4 / R7: bad CRC
        hold_prog(2);
        release_and_clear();
        send_frame(32'h1234_5678, 1'b1, FRAME);
        relay(32'hFFFF_FFFF, 12);
        // R9: abort mid-load, then a clean reload
        hold_prog(2);
        release_and_clear();
        send_frame(32'hFFFF_0000, 1'b0, 13);
        hold_prog(4);
        release_and_clear();
        send_frame(32'h0000_0001, 1'b0, FRAME);
        relay(32'h8001_7E3C, 20);
        hold_prog(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule